// File: doc/BRIEF.md
# Three-Phase Carrier PWM Generator with Cycle Blanking

This block makes a programmable carrier and compares it against three duty words to drive three complementary gate pairs for an inverter bridge. The carrier can be a rising sawtooth, a falling sawtooth or a symmetric triangle. A clock prescaler and a period value set its frequency. Each phase has a high-side and a low-side output. The low side is the inverse of the high side, with a programmable gap during which both are low.

Three groups of per-phase digital comparator flags protect the bridge: over-current, under-current and short. When any of them is set, every gate output is switched off for the rest of the current carrier cycle. A short also raises a fault interrupt for as long as it lasts. A separate sensor-error input keeps all gates off for as long as it is asserted. Duty and period values are written through a small address/data port. They are held in shadow registers and take effect only at a carrier cycle boundary. Single-clock peak and valley strobes let other logic, such as a sampling trigger, follow the carrier.

Top module: `pwm3_carrier_guard`

## Requirements
- R1: The mode register (address 6) selects the carrier shape. Value 0 counts up from 0 to P and wraps to 0. Value 1 counts down from P to 0 and reloads P. Value 2 counts up from 0 to P and back down to 0. Value 3 behaves as value 0.
- R2: With period P (address 3) and prescale S (address 4), the carrier steps once every S+1 clocks. A carrier cycle therefore lasts (P+1)(S+1) clocks in modes 0 and 1, and 2P(S+1) clocks in mode 2.
- R3: A phase's high side is on while the carrier is below that phase's duty word (addresses 0, 1, 2 for phases 0, 1, 2), and its low side is on otherwise. High and low side are never on together. A duty of 0 keeps the high side always off, and a duty above P keeps it always on.
- R4: With a dead time of D clocks (address 5), both outputs of a phase are low for exactly D clocks at every change of the high-side demand, in both directions.
- R5: Duty and period writes are held in shadow registers. They take effect only at a cycle boundary: the wrap to 0 in mode 0, the reload in mode 1, and the return to 0 in mode 2. Prescale, dead time and mode take effect at once.
- R6: An over-current or under-current flag on any phase forces all six outputs low from the next clock until the next cycle boundary, even when the flag drops sooner. Normal output resumes in the following cycle.
- R7: A short flag on any phase drives the fault interrupt high on the next clock for as long as the flag lasts, and blanks the outputs as in R6.
- R8: The sensor-error input forces all six outputs low on the next clock and keeps them low while it stays asserted. Output resumes within two clocks of its release.
- R9: The peak strobe pulses for one clock each time the carrier reaches P, and the valley strobe pulses for one clock each time it reaches 0. Each pulses once per carrier cycle, and the carrier value output shows P and 0 respectively during the pulse.
- R10: While reset is asserted, the carrier is 0 and all gate outputs, strobes and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0-2 duty, 3 period, 4 prescale, 5 dead time, 6 mode) |
| wr_data_i | input | DATA_W | Write data, low bits used |
| oc_hi_i | input | NPH | Per-phase over-current flag |
| uc_lo_i | input | NPH | Per-phase under-current flag |
| short_i | input | NPH | Per-phase short flag |
| hall_err_i | input | 1 | Sensor-error blanking input |
| hs_o | output | NPH | High-side gate drives |
| ls_o | output | NPH | Low-side gate drives |
| fault_irq_o | output | 1 | Fault interrupt request |
| peak_o | output | 1 | Carrier peak strobe |
| valley_o | output | 1 | Carrier valley strobe |
| carrier_o | output | CNT_W | Current carrier value |

## Verification
A wrong count or direction state shows up within one carrier cycle. The valley-to-valley distance and the high-side on-time move away from the values predicted from P, S, duty and D. A stuck dead-time counter or level register appears in the next transition as a shortened gap, a missing gap or overlapping high and low sides. A trip latch that clears early or never clears shows in the same cycle as gate activity before the boundary, or in the next cycle as missing high-side time. Shadowing faults appear as a cycle length or an on-time that changes inside the cycle in which the write happened.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic [1:0] {
    CAR_UP   = 2'd0,
    CAR_DOWN = 2'd1,
    CAR_UPDN = 2'd2
  } car_mode_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRESC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DEAD   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd6;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned DT_W   = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NPH    = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    load_i,
  output logic [NPH*CNT_W-1:0]    duty_act_o,
  output logic [CNT_W-1:0]        per_act_o,
  output logic [CNT_W-1:0]        per_pend_o,
  output logic [PSC_W-1:0]        psc_o,
  output logic [DT_W-1:0]         dt_o,
  output logic [1:0]              mode_o
);
  logic [CNT_W-1:0] per_pend_q, per_act_q;
  logic [PSC_W-1:0] psc_q;
  logic [DT_W-1:0]  dt_q;
  logic [1:0]       mode_q;

  // Live settings and the pending period
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      per_pend_q <= '0;
      per_act_q  <= '0;
      psc_q      <= '0;
      dt_q       <= '0;
      mode_q     <= CAR_UP;
    end else begin
      if (wr_en_i && wr_addr_i == A_PERIOD) per_pend_q <= wr_data_i[CNT_W-1:0];
      if (wr_en_i && wr_addr_i == A_PRESC)  psc_q      <= wr_data_i[PSC_W-1:0];
      if (wr_en_i && wr_addr_i == A_DEAD)   dt_q       <= wr_data_i[DT_W-1:0];
      if (wr_en_i && wr_addr_i == A_MODE)   mode_q     <= wr_data_i[1:0];
      if (load_i) per_act_q <= per_pend_q;
    end
  end

  // Per-phase duty shadow pair
  for (genvar p = 0; p < NPH; p++) begin : g_duty
    logic [CNT_W-1:0] pend_q, act_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == ADDR_W'(p)) pend_q <= wr_data_i[CNT_W-1:0];
        if (load_i) act_q <= pend_q;
      end
    end
    assign duty_act_o[p*CNT_W +: CNT_W] = act_q;
  end

  assign per_act_o  = per_act_q;
  assign per_pend_o = per_pend_q;
  assign psc_o      = psc_q;
  assign dt_o       = dt_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] per_act_i,
  input  logic [CNT_W-1:0] per_pend_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bnd_o,
  output logic             peak_o,
  output logic             valley_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [PSC_W-1:0] psc_cnt_q;
  logic [CNT_W-1:0] cnt_q, nxt, per_eff;
  logic             dir_q, dir_n, bnd, tick;
  logic             peak_q, valley_q;

  assign tick = (psc_cnt_q >= psc_i);

  always_comb begin
    nxt   = cnt_q;
    dir_n = dir_q;
    bnd   = 1'b0;
    if (tick) begin
      case (mode_i)
        CAR_DOWN: begin
          dir_n = 1'b1;
          if (cnt_q == '0) begin
            nxt = per_pend_i;
            bnd = 1'b1;
          end else begin
            nxt = cnt_q - ONE;
          end
        end
        CAR_UPDN: begin
          if (per_act_i == '0) begin
            nxt   = '0;
            dir_n = 1'b1;
            bnd   = 1'b1;
          end else if (dir_q) begin
            if (cnt_q >= per_act_i) begin
              nxt   = cnt_q - ONE;
              dir_n = 1'b0;
            end else begin
              nxt = cnt_q + ONE;
              if (nxt == per_act_i) dir_n = 1'b0;
            end
          end else if (cnt_q == '0) begin
            nxt   = '0;
            dir_n = 1'b1;
            bnd   = 1'b1;
          end else begin
            nxt = cnt_q - ONE;
            if (nxt == '0) begin
              dir_n = 1'b1;
              bnd   = 1'b1;
            end
          end
        end
        default: begin
          dir_n = 1'b1;
          if (cnt_q >= per_act_i) begin
            nxt = '0;
            bnd = 1'b1;
          end else begin
            nxt = cnt_q + ONE;
          end
        end
      endcase
    end
  end

  assign per_eff = bnd ? per_pend_i : per_act_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      psc_cnt_q <= '0;
      cnt_q     <= '0;
      dir_q     <= 1'b1;
      peak_q    <= 1'b0;
      valley_q  <= 1'b0;
    end else begin
      psc_cnt_q <= tick ? '0 : psc_cnt_q + PSC_W'(1);
      cnt_q     <= nxt;
      dir_q     <= dir_n;
      peak_q    <= tick && (nxt == per_eff);
      valley_q  <= tick && (nxt == '0);
    end
  end

  assign cnt_o    = cnt_q;
  assign bnd_o    = bnd;
  assign peak_o   = peak_q;
  assign valley_o = valley_q;
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dt_i,
  input  logic             block_i,
  output logic             hs_o,
  output logic             ls_o
);
  logic            raw_q, lvl_q, lvl_n;
  logic [DT_W-1:0] gap_q, gap_n;
  logic            hs_q, ls_q;

  // A change of demand restarts the gap counter
  always_comb begin
    lvl_n = lvl_q;
    gap_n = gap_q;
    if (raw_q != lvl_q) begin
      lvl_n = raw_q;
      gap_n = dt_i;
    end else if (gap_q != '0) begin
      gap_n = gap_q - DT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      raw_q <= 1'b0;
      lvl_q <= 1'b0;
      gap_q <= '0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      raw_q <= (cnt_i < duty_i);
      lvl_q <= lvl_n;
      gap_q <= gap_n;
      hs_q  <= !block_i &&  lvl_n && (gap_n == '0);
      ls_q  <= !block_i && !lvl_n && (gap_n == '0);
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;
endmodule

// File: rtl/pwm3_guard.sv
module pwm3_guard #(
  parameter int unsigned NPH = 3
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [NPH-1:0] oc_hi_i,
  input  logic [NPH-1:0] uc_lo_i,
  input  logic [NPH-1:0] short_i,
  input  logic           hall_err_i,
  input  logic           cyc_start_i,
  output logic           block_o,
  output logic           irq_o
);
  logic trip_q, irq_q, any_trip;

  assign any_trip = |(oc_hi_i | uc_lo_i | short_i);

  // A new trip wins over the boundary clear
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      trip_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (any_trip)         trip_q <= 1'b1;
      else if (cyc_start_i) trip_q <= 1'b0;
      irq_q <= |short_i;
    end
  end

  assign block_o = trip_q | any_trip | hall_err_i;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pwm3_carrier_guard.sv
module pwm3_carrier_guard
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned DT_W   = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NPH    = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NPH-1:0]    oc_hi_i,
  input  logic [NPH-1:0]    uc_lo_i,
  input  logic [NPH-1:0]    short_i,
  input  logic              hall_err_i,
  output logic [NPH-1:0]    hs_o,
  output logic [NPH-1:0]    ls_o,
  output logic              fault_irq_o,
  output logic              peak_o,
  output logic              valley_o,
  output logic [CNT_W-1:0]  carrier_o
);
  logic [NPH*CNT_W-1:0] duty_act;
  logic [CNT_W-1:0]     per_act, per_pend, cnt;
  logic [PSC_W-1:0]     psc_val;
  logic [DT_W-1:0]      dt_val;
  logic [1:0]           mode_val;
  logic                 bnd, block;

  pwm3_regs #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .DT_W(DT_W), .DATA_W(DATA_W), .NPH(NPH)
  ) regs_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .load_i(bnd),
    .duty_act_o(duty_act), .per_act_o(per_act), .per_pend_o(per_pend),
    .psc_o(psc_val), .dt_o(dt_val), .mode_o(mode_val)
  );

  pwm3_carrier #(.CNT_W(CNT_W), .PSC_W(PSC_W)) car_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .psc_i(psc_val), .mode_i(mode_val),
    .per_act_i(per_act), .per_pend_i(per_pend),
    .cnt_o(cnt), .bnd_o(bnd), .peak_o(peak_o), .valley_o(valley_o)
  );

  pwm3_guard #(.NPH(NPH)) guard_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .oc_hi_i(oc_hi_i), .uc_lo_i(uc_lo_i), .short_i(short_i),
    .hall_err_i(hall_err_i), .cyc_start_i(bnd),
    .block_o(block), .irq_o(fault_irq_o)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    pwm3_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) ph_i (
      .clk_i(clk_i), .rst_i(rst_i),
      .cnt_i(cnt), .duty_i(duty_act[p*CNT_W +: CNT_W]),
      .dt_i(dt_val), .block_i(block),
      .hs_o(hs_o[p]), .ls_o(ls_o[p])
    );
  end

  assign carrier_o = cnt;
endmodule

// File: rtl/pwm3_carrier_guard_chk.sv
module pwm3_carrier_guard_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 6,
  parameter int unsigned NPH   = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [NPH-1:0]   oc_hi_i,
  input logic [NPH-1:0]   uc_lo_i,
  input logic [NPH-1:0]   short_i,
  input logic             hall_err_i,
  input logic [NPH-1:0]   hs_o,
  input logic [NPH-1:0]   ls_o,
  input logic             fault_irq_o,
  input logic             valley_o,
  input logic [CNT_W-1:0] carrier_o,
  input logic [DT_W-1:0]  dt_val
);
  // R3
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hs_o & ls_o) == '0);

  for (genvar i = 0; i < NPH; i++) begin : g_gap
    // R4
    rise_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (dt_val != '0 && $rose(hs_o[i])) |-> !$past(ls_o[i]));
    // R4
    fall_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (dt_val != '0 && $rose(ls_o[i])) |-> !$past(hs_o[i]));
  end

  // R6
  trip_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|(oc_hi_i | uc_lo_i)) |=> (hs_o == '0 && ls_o == '0));

  // R7
  short_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|short_i) |=> fault_irq_o);

  // R8
  hall_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hall_err_i |=> (hs_o == '0 && ls_o == '0));

  // R9
  valley_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    valley_o |-> carrier_o == '0);

  // R10
  reset_off_chk: assert property (@(posedge clk_i)
    rst_i |=> (hs_o == '0 && ls_o == '0 && carrier_o == '0));
endmodule

bind pwm3_carrier_guard pwm3_carrier_guard_chk #(
  .CNT_W(CNT_W), .DT_W(DT_W), .NPH(NPH)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i),
  .oc_hi_i(oc_hi_i), .uc_lo_i(uc_lo_i), .short_i(short_i),
  .hall_err_i(hall_err_i),
  .hs_o(hs_o), .ls_o(ls_o), .fault_irq_o(fault_irq_o),
  .valley_o(valley_o), .carrier_o(carrier_o), .dt_val(dt_val)
);

// File: tb/pwm3_carrier_guard_tb.sv
`timescale 1ns/1ps
module pwm3_carrier_guard_tb_top;
  localparam int CNT_W = 12;
  localparam int NPH   = 3;
  localparam int NV    = 7;
  // mode, period, prescale, duty, dead, cycle clocks, hs clocks, ls clocks
  localparam int VT [NV][8] = '{
    '{0, 19, 0, 10, 3, 20,  7,  7},
    '{0,  9, 2,  4, 2, 30, 10, 16},
    '{1, 15, 0,  5, 1, 16,  4, 10},
    '{2, 10, 0,  4, 2, 20,  5, 11},
    '{2,  8, 1,  3, 0, 32, 10, 22},
    '{0, 11, 0,  0, 2, 12,  0, 12},
    '{0, 11, 0, 12, 2, 12, 12,  0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [15:0]      wr_data = '0;
  logic [NPH-1:0]   oc_hi = '0, uc_lo = '0, short_f = '0;
  logic             hall_err = 1'b0;
  logic [NPH-1:0]   hs, ls;
  logic             irq, peak, valley;
  logic [CNT_W-1:0] carrier;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  pwm3_carrier_guard dut_i (
    .clk_i(clk), .rst_i(rst),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .oc_hi_i(oc_hi), .uc_lo_i(uc_lo), .short_i(short_f),
    .hall_err_i(hall_err),
    .hs_o(hs), .ls_o(ls), .fault_irq_o(irq),
    .peak_o(peak), .valley_o(valley), .carrier_o(carrier)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg(input int m, input int p, input int s, input int d, input int dt);
    wr(5, dt); wr(4, s); wr(6, m); wr(3, p);
    wr(0, d); wr(1, d); wr(2, d);
  endtask

  task automatic wait_valley();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!valley && guard < 10000);
  endtask

  // Starts at a valley sample, ends at the next one
  task automatic measure(output int n, output int hc[NPH], output int lc[NPH], output int both);
    n = 0; both = 0;
    for (int p = 0; p < NPH; p++) begin hc[p] = 0; lc[p] = 0; end
    do begin
      @(negedge clk);
      n++;
      for (int p = 0; p < NPH; p++) begin
        hc[p] += int'(hs[p]);
        lc[p] += int'(ls[p]);
        both  += int'(hs[p] & ls[p]);
      end
    end while (!valley && n < 10000);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n, both, bad, pk, vl, pkval;
    int hc[NPH];
    int lc[NPH];

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(carrier == '0 && hs == '0 && ls == '0, "R10 carrier/gates in reset", int'(carrier) + int'(hs) + int'(ls), 0);
    chk(!peak && !valley && !irq, "R10 strobes/irq in reset", int'(peak) + int'(valley) + int'(irq), 0);
    rst = 1'b0;

    // Vector table: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4]);
      repeat (3) wait_valley();
      measure(n, hc, lc, both);
      chk(n == VT[v][5], $sformatf("R1 R2 cycle length vec %0d", v), n, VT[v][5]);
      for (int p = 0; p < NPH; p++) begin
        chk(hc[p] == VT[v][6], $sformatf("R3 R4 high-side clocks vec %0d ph %0d", v, p), hc[p], VT[v][6]);
        chk(lc[p] == VT[v][7], $sformatf("R3 R4 low-side clocks vec %0d ph %0d", v, p), lc[p], VT[v][7]);
      end
      chk(both == 0, $sformatf("R3 overlap vec %0d", v), both, 0);
    end

    // R1 mode 3 acts as mode 0
    do_reset();
    cfg(3, 19, 0, 10, 3);
    repeat (3) wait_valley();
    measure(n, hc, lc, both);
    chk(n == 20 && hc[0] == 7, "R1 mode 3 as count-up", n, 20);

    // R5 shadowing of period and duty
    do_reset();
    cfg(0, 19, 0, 10, 0);
    repeat (3) wait_valley();
    n = 0; pk = 0;
    repeat (12) begin @(negedge clk); n++; end
    wr(0, 15); n++;
    wr(3, 29); n++;
    do begin
      @(negedge clk);
      n++;
      pk += int'(hs[0]);
    end while (!valley && n < 1000);
    chk(n == 20, "R5 current cycle keeps old period", n, 20);
    chk(pk == 0, "R5 new duty not live mid-cycle", pk, 0);
    measure(n, hc, lc, both);
    chk(n == 30, "R5 new period at boundary", n, 30);
    chk(hc[0] == 15 && hc[1] == 10, "R5 new duty at boundary", hc[0], 15);

    // R6 over-current trip, then resume
    do_reset();
    cfg(0, 19, 0, 10, 0);
    repeat (3) wait_valley();
    repeat (2) @(negedge clk);
    oc_hi = 3'b010;
    @(negedge clk);
    oc_hi = '0;
    bad = 0;
    while (!valley) begin
      bad += int'((hs | ls) != '0);
      @(negedge clk);
    end
    chk(bad == 0, "R6 over-current blanks rest of cycle", bad, 0);
    measure(n, hc, lc, both);
    chk(hc[0] == 10, "R6 resumes next cycle", hc[0], 10);

    // R6 under-current trip
    repeat (5) @(negedge clk);
    uc_lo = 3'b100;
    @(negedge clk);
    uc_lo = '0;
    bad = 0;
    while (!valley) begin
      bad += int'((hs | ls) != '0);
      @(negedge clk);
    end
    chk(bad == 0, "R6 under-current blanks rest of cycle", bad, 0);

    // R7 short raises interrupt and blanks
    wait_valley();
    repeat (2) @(negedge clk);
    short_f = 3'b001;
    @(negedge clk);
    chk(irq == 1'b1, "R7 interrupt after short", int'(irq), 1);
    short_f = '0;
    @(negedge clk);
    chk(irq == 1'b0, "R7 interrupt follows short", int'(irq), 0);
    bad = 0;
    while (!valley) begin
      bad += int'((hs | ls) != '0);
      @(negedge clk);
    end
    chk(bad == 0, "R7 short blanks rest of cycle", bad, 0);

    // R8 sensor error blanking across a boundary
    wait_valley();
    hall_err = 1'b1;
    @(negedge clk);
    bad = 0;
    repeat (25) begin
      bad += int'((hs | ls) != '0);
      @(negedge clk);
    end
    hall_err = 1'b0;
    chk(bad == 0, "R8 blanked while error held", bad, 0);
    repeat (2) @(negedge clk);
    chk((hs | ls) == 3'b111, "R8 resumes after release", int'(hs | ls), 7);

    // R9 strobes in count-up mode
    wait_valley();
    chk(carrier == '0, "R9 carrier 0 on valley", int'(carrier), 0);
    pk = 0; vl = 0; pkval = -1;
    repeat (20) begin
      @(negedge clk);
      if (peak) begin pk++; pkval = int'(carrier); end
      vl += int'(valley);
    end
    chk(pk == 1 && vl == 1, "R9 one peak and valley per cycle", pk * 10 + vl, 11);
    chk(pkval == 19, "R9 carrier at peak", pkval, 19);

    // R9 strobes in triangle mode
    do_reset();
    cfg(2, 10, 0, 4, 0);
    repeat (3) wait_valley();
    pk = 0; pkval = -1;
    repeat (20) begin
      @(negedge clk);
      if (peak) begin pk++; pkval = int'(carrier); end
    end
    chk(pk == 1 && pkval == 10, "R9 triangle peak", pkval, 10);

    // R10 reset while running
    rst = 1'b1;
    @(negedge clk);
    chk(hs == '0 && ls == '0 && carrier == '0, "R10 mid-run reset", int'(hs) + int'(ls) + int'(carrier), 0);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule